// File: doc/BRIEF.md
# Vectored Two-Line Interrupt Controller

The controller gathers 96 level-sensitive interrupt sources into three banks of 32 and presents them to a processor on two request lines. One is a normal request and one is a fast request. Each source has a pending bit that tracks its input level. A per-bit mask suppresses a source. A per-bit route flag sends an unmasked source to the fast line as well. A vector register gives software a byte offset it can use to index a handler table. Each source takes four bytes, so the offset is the source number times four.

Software reaches the controller through a simple register bus. The bus has a write strobe, a word address, write data and combinational read data. Each register group spans three consecutive words, one word per bank. Address bits [3:2] pick the bank. The fast-pending group keeps a sticky record of fast requests, and software clears it by writing ones. The normal pending group is read-only. The whole window is 0x400 bytes.

Top module: `vic_ctrl`

## Requirements
- R1: Source n appears in bank n/32 at bit n%32 of the pending word at 0x040 + 4*bank, one clock after its input level is sampled. The pending bit is 1 while the input is high and 0 while it is low.
- R2: `irq_o` is high exactly when some pending bit has its mask bit (group 0x080, 1 = masked) clear.
- R3: `fiq_o` is high exactly when some pending bit is unmasked and has its route bit (group 0x060, 1 = fast) set.
- R4: The vector word at 0x000 becomes (bank*32 + lowest active bit of that bank)*4 one clock after the outputs change. Here "active" means pending and unmasked, and the bank used is the highest-numbered bank that has an active bit.
- R5: While no source is active, the vector word keeps its last value.
- R6: A fast-pending bit (group 0x050) is set and stays set while its source drives the fast line. A write clears every bit written as 1 and leaves the bits written as 0.
- R7: Writes to the pending group are accepted and change nothing.
- R8: The base word at 0x004 stores the written data with bits [1:0] forced to 0. The protect word at 0x008 reads back what was written.
- R9: The route, enable (group 0x070) and mask words read back what was written. Enable bits have no effect on `irq_o`, `fiq_o` or the vector.
- R10: Reads from unmapped offsets return 0 and writes to them change nothing. Unmapped offsets include bank index 3 in any group and every group other than 0x000 to 0x080.
- R11: After reset every register reads 0 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 96 | Level-sensitive interrupt inputs |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Byte address of the accessed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the sources and bus inputs change only between clock edges and are held low-risk through reset. They also assume that software never clears a fast-pending bit in the same cycle as its source still routes to the fast line. The stimulus changes inputs on the falling edge and drops the relevant source before clearing its fast-pending bit. It always waits the stated one- and two-clock latencies before it compares anything.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BANK_W = 32;
  localparam int POS_W  = $clog2(BANK_W);

  typedef enum logic [5:0] {
    GRP_CTRL  = 6'h00,
    GRP_PEND  = 6'h04,
    GRP_FPEND = 6'h05,
    GRP_ROUTE = 6'h06,
    GRP_EN    = 6'h07,
    GRP_MASK  = 6'h08
  } grp_e;

  // index of lowest set bit (0 when none)
  function automatic logic [POS_W-1:0] lowest_bit(input logic [BANK_W-1:0] v);
    logic [POS_W-1:0] r;
    r = '0;
    for (int i = BANK_W - 1; i >= 0; i--) begin
      if (v[i]) r = POS_W'(i);
    end
    return r;
  endfunction

  // byte offset of a source within the handler table
  function automatic logic [31:0] vec_offset(input int bank, input logic [POS_W-1:0] pos);
    return 32'((bank * BANK_W + int'(pos)) * 4);
  endfunction
endpackage

// File: rtl/vic_bank.sv
module vic_bank
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src_i,
  input  logic              we_route_i,
  input  logic              we_en_i,
  input  logic              we_mask_i,
  input  logic              we_fclr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] fpend_o,
  output logic [BANK_W-1:0] route_o,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] mask_o,
  output logic              act_any_o,
  output logic              fast_any_o,
  output logic [POS_W-1:0]  low_pos_o
);
  logic [BANK_W-1:0] pend_q, fpend_q, route_q, en_q, mask_q;
  logic [BANK_W-1:0] active_w, fast_w, fclr_w;

  assign active_w = pend_q & ~mask_q;
  assign fast_w   = active_w & route_q;
  assign fclr_w   = we_fclr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      fpend_q <= '0;
      route_q <= '0;
      en_q    <= '0;
      mask_q  <= '0;
    end else begin
      pend_q  <= src_i;
      fpend_q <= (fpend_q & ~fclr_w) | fast_w;
      if (we_route_i) route_q <= wdata_i;
      if (we_en_i)    en_q    <= wdata_i;
      if (we_mask_i)  mask_q  <= wdata_i;
    end
  end

  assign pend_o     = pend_q;
  assign fpend_o    = fpend_q;
  assign route_o    = route_q;
  assign en_o       = en_q;
  assign mask_o     = mask_q;
  assign act_any_o  = |active_w;
  assign fast_any_o = |fast_w;
  assign low_pos_o  = lowest_bit(active_w);

  AST_PEND_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend_q == $past(src_i)); // R1

  AST_FPEND_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fpend_q & $past(fast_w)) == $past(fast_w)); // R6
endmodule

// File: rtl/vic_vector.sv
module vic_vector
  import vic_pkg::*;
#(
  parameter int NBANK = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBANK-1:0]            act_any_i,
  input  logic [NBANK-1:0]            fast_any_i,
  input  logic [NBANK-1:0][POS_W-1:0] low_pos_i,
  output logic                        irq_o,
  output logic                        fiq_o,
  output logic [31:0]                 vec_o
);
  logic        win_any;
  logic [31:0] win_vec, vec_q;

  // last bank with an active bit wins
  always_comb begin
    win_any = 1'b0;
    win_vec = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (act_any_i[b]) begin
        win_any = 1'b1;
        win_vec = vec_offset(b, low_pos_i[b]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       vec_q <= '0;
    else if (win_any) vec_q <= win_vec;
  end

  assign irq_o = |act_any_i;
  assign fiq_o = |fast_any_i;
  assign vec_o = vec_q;

  AST_FIQ_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o); // R3

  AST_VEC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(irq_o)) |-> vec_q == $past(vec_q)); // R5

  AST_VEC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q[1:0] == 2'b00); // R4
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NBANK = NUM_SRC / BANK_W;

  logic [5:0] grp_w;
  logic [1:0] word_w;
  logic [31:0] base_q, prot_q, vec_w;

  logic [NBANK-1:0][BANK_W-1:0] pend_a, fpend_a, route_a, en_a, mask_a;
  logic [NBANK-1:0]             act_any, fast_any;
  logic [NBANK-1:0][POS_W-1:0]  low_pos;

  assign grp_w  = 6'(addr_i[ADDR_W-1:4]);
  assign word_w = addr_i[3:2];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_w;
    assign hit_w = wr_i && (int'(word_w) == b);
    vic_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i[b*BANK_W +: BANK_W]),
      .we_route_i (hit_w && grp_w == GRP_ROUTE),
      .we_en_i    (hit_w && grp_w == GRP_EN),
      .we_mask_i  (hit_w && grp_w == GRP_MASK),
      .we_fclr_i  (hit_w && grp_w == GRP_FPEND),
      .wdata_i    (wdata_i),
      .pend_o     (pend_a[b]),
      .fpend_o    (fpend_a[b]),
      .route_o    (route_a[b]),
      .en_o       (en_a[b]),
      .mask_o     (mask_a[b]),
      .act_any_o  (act_any[b]),
      .fast_any_o (fast_any[b]),
      .low_pos_o  (low_pos[b])
    );
  end

  vic_vector #(.NBANK(NBANK)) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_any_i  (act_any),
    .fast_any_i (fast_any),
    .low_pos_i  (low_pos),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .vec_o      (vec_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      prot_q <= '0;
    end else if (wr_i && grp_w == GRP_CTRL) begin
      if (word_w == 2'd1) base_q <= {wdata_i[31:2], 2'b00};
      if (word_w == 2'd2) prot_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (grp_w == GRP_CTRL) begin
      case (word_w)
        2'd0:    rdata_o = vec_w;
        2'd1:    rdata_o = base_q;
        2'd2:    rdata_o = prot_q;
        default: rdata_o = '0;
      endcase
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(word_w) == b) begin
          case (grp_w)
            GRP_PEND:  rdata_o = pend_a[b];
            GRP_FPEND: rdata_o = fpend_a[b];
            GRP_ROUTE: rdata_o = route_a[b];
            GRP_EN:    rdata_o = en_a[b];
            GRP_MASK:  rdata_o = mask_a[b];
            default:   rdata_o = '0;
          endcase
        end
      end
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !$past(rst_n) |-> !irq_o && !fiq_o); // R11
endmodule

// File: tb/tb_vic_ctrl.sv
`timescale 1ns/1ps
module tb_vic_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src_i = '0;
  logic        wr_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  always #2.5 clk = ~clk;

  vic_ctrl dut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_i(wr_i), .addr_i(addr_i),
                .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t; // kind 0 rdata,1 irq,2 fiq
  item_t sb_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_mask [3];
  logic [31:0] m_route[3];
  logic [31:0] m_vec = '0;

  function automatic bit m_active(int n);
    return src_i[n] && !m_mask[n/32][n%32];
  endfunction
  function automatic logic [31:0] m_irq();
    for (int n = 0; n < 96; n++) if (m_active(n)) return 1;
    return 0;
  endfunction
  function automatic logic [31:0] m_fiq();
    for (int n = 0; n < 96; n++) if (m_active(n) && m_route[n/32][n%32]) return 1;
    return 0;
  endfunction
  // highest bank, then lowest bit in it
  function automatic void m_vec_update();
    for (int bk = 2; bk >= 0; bk--) begin
      for (int p = 0; p < 32; p++) begin
        if (m_active(bk*32 + p)) begin m_vec = (bk*32 + p) * 4; return; end
      end
    end
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_i = 0;
  endtask
  task automatic expect_rd(logic [9:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk); addr_i = a; #1;
    it.kind = 0; it.exp = e; it.tag = tag; sb_q.push_back(it);
  endtask
  task automatic expect_line(int k, logic [31:0] e, string tag);
    item_t it;
    #1; it.kind = k; it.exp = e; it.tag = tag; sb_q.push_back(it);
  endtask
  task automatic drive_src(int n, bit v);
    @(negedge clk); src_i[n] = v; tick(2); m_vec_update();
  endtask
  task automatic check_lines(string tag);
    expect_line(1, m_irq(), {tag, " irq"});
    expect_line(2, m_fiq(), {tag, " fiq"});
  endtask

  // monitor: compares as results appear
  initial begin
    item_t it;
    logic [31:0] got;
    forever begin
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      got = (it.kind == 0) ? rdata_o : (it.kind == 1) ? 32'(irq_o) : 32'(fiq_o);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 3; b++) begin m_mask[b] = 0; m_route[b] = 0; end
    tick(3); rst_n = 1; tick(1);
    // R11 reset state
    check_lines("R11");
    foreach (m_mask[b]) begin
      expect_rd(10'h040 + 10'(4*b), 0, "R11 pend");
      expect_rd(10'h080 + 10'(4*b), 0, "R11 mask");
    end
    expect_rd(10'h000, 0, "R11 vec");
    expect_rd(10'h004, 0, "R11 base");

    // R1, R2, R4
    drive_src(5, 1);
    expect_rd(10'h040, 32'h20, "R1 bank0");
    check_lines("R2 src5");
    expect_rd(10'h000, m_vec, "R4 src5");
    drive_src(40, 1);
    expect_rd(10'h044, 32'h100, "R1 bank1");
    expect_rd(10'h000, m_vec, "R4 bank1 wins");
    drive_src(33, 1);
    expect_rd(10'h000, m_vec, "R4 lowest bit");

    // R2/R4 mask bank1
    bus_wr(10'h084, 32'hffff_ffff); m_mask[1] = 32'hffff_ffff; tick(1); m_vec_update();
    expect_rd(10'h000, m_vec, "R4 masked bank1");
    check_lines("R2 partial mask");
    expect_rd(10'h084, 32'hffff_ffff, "R9 mask rb");

    // R5 all masked
    bus_wr(10'h080, 32'hffff_ffff); m_mask[0] = 32'hffff_ffff; tick(2); m_vec_update();
    check_lines("R2 all masked");
    expect_rd(10'h000, m_vec, "R5 vec hold");

    // R3/R6
    bus_wr(10'h080, 0); m_mask[0] = 0;
    bus_wr(10'h060, 32'h20); m_route[0] = 32'h20; tick(1);
    check_lines("R3 routed");
    expect_rd(10'h060, 32'h20, "R9 route rb");
    expect_rd(10'h050, 32'h20, "R6 captured");
    drive_src(5, 0);
    check_lines("R3 source gone");
    expect_rd(10'h050, 32'h20, "R6 sticky");
    bus_wr(10'h050, 32'h1); tick(1);
    expect_rd(10'h050, 32'h20, "R6 zero bits kept");
    bus_wr(10'h050, 32'h20); tick(1);
    expect_rd(10'h050, 0, "R6 w1c");

    // R7
    bus_wr(10'h044, 32'hffff_ffff); tick(1);
    expect_rd(10'h044, 32'h102, "R7 pend write ignored");
    expect_rd(10'h040, 0, "R7 bank0");

    // R8
    bus_wr(10'h004, 32'h1237); expect_rd(10'h004, 32'h1234, "R8 base");
    bus_wr(10'h008, 32'ha5);   expect_rd(10'h008, 32'ha5, "R8 protect");

    // R9 enable no effect
    bus_wr(10'h078, 32'h0000_ffff); tick(1);
    expect_rd(10'h078, 32'h0000_ffff, "R9 enable rb");
    drive_src(70, 1);
    check_lines("R9 enable ignored");
    expect_rd(10'h000, m_vec, "R9 vec unaffected");

    // R10 unmapped
    bus_wr(10'h06c, 32'hdead_beef); tick(1);
    expect_rd(10'h06c, 0, "R10 bank3 read");
    expect_rd(10'h060, 32'h20, "R10 route b0");
    expect_rd(10'h064, 0, "R10 route b1");
    expect_rd(10'h068, 0, "R10 route b2");
    expect_rd(10'h200, 0, "R10 far offset");
    expect_rd(10'h00c, 0, "R10 ctrl word3");

    // R4 boundary
    drive_src(95, 1);
    expect_rd(10'h000, m_vec, "R4 top source");
    expect_rd(10'h048, 32'h8000_0040, "R1 bank2");

    tick(2);
    wait (sb_q.size() == 0); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule